// File: doc/BRIEF.md
# Calendar Alarm with Shared Interrupt and Clock Output

This block watches the running calendar (second, minute, hour, date, month, weekday) and compares it with six alarm bytes. Bit 7 of each alarm byte arms that field, and bits 6:0 hold the value to compare. Only armed fields take part in the comparison. This makes a recurring alarm easy to set up: arming only the second field fires once a minute, and arming the month field with the others fires once a year. A match sets a status flag and pulls an active-low, open-drain pin low. The pin is modelled as a drive-low enable.

A mode input chooses between two behaviours. In latched mode the pin stays low until the flag is cleared. In pulsed mode every match holds the pin low for a fixed number of oscillator cycles, 8192 by default, which is 250 ms at 32.768 kHz. When the rate select input is nonzero, the same pin carries a square wave divided down from the oscillator clock, and alarm matching is switched off.

A keep-alive input decides whether the alarm and the clock output keep working while the chip runs from its backup supply. The block is clocked by the oscillator. The calendar supplies the one-second strobe and the field values.

Top module: `rtc_alarm_irq`

## Requirements
- R1: A match is evaluated only in a cycle with `sec_tick` high. It occurs when every alarm byte whose bit 7 is 1 has bits 6:0 equal to bits 6:0 of the matching calendar input. Bytes with bit 7 at 0 are ignored, whatever their value.
- R2: If no alarm byte has bit 7 set, no match occurs, even when all values are equal.
- R3: With `pulse_mode`=0 (state LATCH), a match raises `alm_flag` and `irq_oe` at the clock edge that samples it. `irq_oe` stays high until the flag is cleared.
- R4: With `pulse_mode`=1 (state PULSE), a match holds `irq_oe` high for exactly PULSE_CYC cycles, counted from the sampling edge. A new match during the pulse restarts the count.
- R5: Every match sets `alm_flag` in either mode, and the flag stays set after a pulse ends.
- R6: `flag_clr` clears `alm_flag` at the next edge and releases a latched pin. A match in the same cycle takes precedence, so the flag stays set.
- R7: With `auto_clr`=1, a one-cycle `flag_rd` strobe clears the flag at the second edge after the strobe. The flag still reads 1 after the first edge. With `auto_clr`=0, `flag_rd` has no effect.
- R8: A nonzero `fsel` disables matching, and the flag stays unchanged. The pin then drives low while a tap of a free-running prescaler is 0. Codes 1..10 tap bit c-1, which divides the clock by 2^c. Codes 11, 12, 13, 14 and 15 tap bits 14, 15, 16, 18 and 19. The duty cycle is exactly 50 %.
- R9: `irq_oe`=1 means the pin is pulled low. `irq_oe`=0 means the pin is released.
- R10: With `batt_mode`=1 and `batt_keep`=0, `irq_oe` is 0 and matches are ignored. With `batt_keep`=1, the block behaves as it does on main power.
- R11: After reset, `alm_flag`=0 and `irq_oe`=0 when `fsel`=0.
- R12: When the alarm is disabled (by R8 or R10), the state machine returns to IDLE. A latched pin therefore stays released when the alarm is enabled again, while the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| cur_sec | input | 8 | Current second |
| cur_min | input | 8 | Current minute |
| cur_hour | input | 8 | Current hour |
| cur_date | input | 8 | Current date |
| cur_mon | input | 8 | Current month |
| cur_dow | input | 8 | Current weekday |
| alm_sec | input | 8 | Second alarm, bit 7 arms |
| alm_min | input | 8 | Minute alarm, bit 7 arms |
| alm_hour | input | 8 | Hour alarm, bit 7 arms |
| alm_date | input | 8 | Date alarm, bit 7 arms |
| alm_mon | input | 8 | Month alarm, bit 7 arms |
| alm_dow | input | 8 | Weekday alarm, bit 7 arms |
| pulse_mode | input | 1 | 0 latched, 1 pulsed |
| auto_clr | input | 1 | Clear flag after a read |
| flag_rd | input | 1 | Status read strobe |
| flag_clr | input | 1 | Software flag clear |
| fsel | input | 4 | Clock output rate, 0 off |
| batt_mode | input | 1 | Running on backup supply |
| batt_keep | input | 1 | Keep functions alive on backup |
| alm_flag | output | 1 | Alarm status flag |
| irq_oe | output | 1 | Pin pull-low enable |

## Verification
The hardest case to reach is a latched alarm that is taken away by a backup-power switch and then given back. Its effect shows only as a pin that stays released while the flag still holds 1. The stimulus latches a match, enters backup mode without keep-alive, clears the flag and ticks a match that must be ignored. It then sets keep-alive and checks that the pin stays released until a fresh match arrives. Pulse length is checked at both edges of its window, and a second match in the middle of a pulse must stretch it.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int NFIELD = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_PULSE = 2'd2
    } irq_state_e;

    // Prescaler bit position plus one for each rate code.
    function automatic logic [4:0] rate_exp(input logic [3:0] code);
        logic [4:0] e;
        unique case (code)
            4'd11:   e = 5'd15;
            4'd12:   e = 5'd16;
            4'd13:   e = 5'd17;
            4'd14:   e = 5'd19;
            4'd15:   e = 5'd20;
            4'd0:    e = 5'd1;
            default: e = {1'b0, code};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/alm_field_match.sv
module alm_field_match #(
    parameter int NF = 6,
    parameter int FW = 8
) (
    input  logic            tick,
    input  logic            active,
    input  logic [NF*FW-1:0] cur_vec,
    input  logic [NF*FW-1:0] alm_vec,
    output logic            any_en,
    output logic            hit
);
    localparam int VW = FW - 1;

    logic [NF-1:0] armed;
    logic [NF-1:0] field_ok;

    for (genvar i = 0; i < NF; i++) begin : g_field
        assign armed[i]    = alm_vec[i*FW + VW];
        assign field_ok[i] = !armed[i] ||
                             (alm_vec[i*FW +: VW] == cur_vec[i*FW +: VW]);
    end

    assign any_en = |armed;
    assign hit    = tick && active && any_en && (&field_ok);
endmodule

// File: rtl/alm_status.sv
module alm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic flag_rd,
    input  logic auto_clr,
    output logic flag,
    output logic clearing
);
    logic rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            flag <= 1'b0;
        end else begin
            rd_q <= flag_rd && auto_clr;
            if (hit)
                flag <= 1'b1;
            else if (flag_clr || rd_q)
                flag <= 1'b0;
        end
    end

    assign clearing = flag && (flag_clr || rd_q) && !hit;
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_CYC = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       pulse_mode,
    input  logic       active,
    input  logic       flag_clearing,
    output irq_state_e st,
    output logic       alarm_drive
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

    irq_state_e       nxt;
    logic [CNT_W-1:0] cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (hit && pulse_mode)
            cnt <= CNT_LOAD;
        else if (st == ST_PULSE && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (hit) nxt = pulse_mode ? ST_PULSE : ST_LATCH;
            end
            ST_LATCH: begin
                if (hit)                nxt = pulse_mode ? ST_PULSE : ST_LATCH;
                else if (flag_clearing) nxt = ST_IDLE;
            end
            ST_PULSE: begin
                if (hit)             nxt = pulse_mode ? ST_PULSE : ST_LATCH;
                else if (cnt == '0)  nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        if (!active) nxt = ST_IDLE;
    end

    // Outputs
    always_comb begin
        alarm_drive = 1'b0;
        unique case (st)
            ST_LATCH, ST_PULSE: alarm_drive = active;
            default:            alarm_drive = 1'b0;
        endcase
    end
endmodule

// File: rtl/freq_tap.sv
module freq_tap
    import rtc_alarm_pkg::*;
#(
    parameter int PRESC_W = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [3:0] fsel,
    output logic       drive_low
);
    logic [PRESC_W-1:0] presc;
    logic [4:0]         tap;
    logic               level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc <= '0;
        else        presc <= presc + 1'b1;
    end

    always_comb begin
        tap   = rate_exp(fsel) - 5'd1;
        level = (int'(tap) < PRESC_W) ? presc[tap] : 1'b0;
    end

    assign drive_low = active && !level;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
#(
    parameter int FIELD_W   = 8,
    parameter int PULSE_CYC = 8192,
    parameter int PRESC_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [FIELD_W-1:0] cur_sec,
    input  logic [FIELD_W-1:0] cur_min,
    input  logic [FIELD_W-1:0] cur_hour,
    input  logic [FIELD_W-1:0] cur_date,
    input  logic [FIELD_W-1:0] cur_mon,
    input  logic [FIELD_W-1:0] cur_dow,
    input  logic [FIELD_W-1:0] alm_sec,
    input  logic [FIELD_W-1:0] alm_min,
    input  logic [FIELD_W-1:0] alm_hour,
    input  logic [FIELD_W-1:0] alm_date,
    input  logic [FIELD_W-1:0] alm_mon,
    input  logic [FIELD_W-1:0] alm_dow,
    input  logic               pulse_mode,
    input  logic               auto_clr,
    input  logic               flag_rd,
    input  logic               flag_clr,
    input  logic [3:0]         fsel,
    input  logic               batt_mode,
    input  logic               batt_keep,
    output logic               alm_flag,
    output logic               irq_oe
);
    localparam int VEC_W = NFIELD * FIELD_W;

    logic [VEC_W-1:0] cur_vec, alm_vec;
    logic             power_ok, alarm_active, freq_active;
    logic             any_en, hit, clearing, alarm_drive, freq_low;
    irq_state_e       st_w;

    assign cur_vec = {cur_dow, cur_mon, cur_date, cur_hour, cur_min, cur_sec};
    assign alm_vec = {alm_dow, alm_mon, alm_date, alm_hour, alm_min, alm_sec};

    assign power_ok     = !batt_mode || batt_keep;
    assign alarm_active = power_ok && (fsel == 4'd0);
    assign freq_active  = power_ok && (fsel != 4'd0);

    alm_field_match #(.NF(NFIELD), .FW(FIELD_W)) match_i (
        .tick   (sec_tick),
        .active (alarm_active),
        .cur_vec(cur_vec),
        .alm_vec(alm_vec),
        .any_en (any_en),
        .hit    (hit)
    );

    alm_status status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .flag_clr(flag_clr),
        .flag_rd (flag_rd),
        .auto_clr(auto_clr),
        .flag    (alm_flag),
        .clearing(clearing)
    );

    irq_fsm #(.PULSE_CYC(PULSE_CYC)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .pulse_mode   (pulse_mode),
        .active       (alarm_active),
        .flag_clearing(clearing),
        .st           (st_w),
        .alarm_drive  (alarm_drive)
    );

    freq_tap #(.PRESC_W(PRESC_W)) freq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (freq_active),
        .fsel     (fsel),
        .drive_low(freq_low)
    );

    assign irq_oe = alarm_drive || freq_low;
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk
    import rtc_alarm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       hit,
    input logic       any_en,
    input logic       alm_flag,
    input logic       flag_clr,
    input logic       alarm_active,
    input logic [3:0] fsel,
    input logic       batt_mode,
    input logic       batt_keep,
    input logic       irq_oe,
    input irq_state_e st
);
    a_r1_hit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> sec_tick);

    a_r2_unarmed_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_en && !alm_flag) |=> !alm_flag);

    a_r5_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alm_flag);

    a_r6_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !alm_flag);

    a_r8_freq_blocks_match: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel != 4'd0) |-> !hit);

    a_r10_backup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_mode && !batt_keep) |-> !irq_oe);

    a_r12_off_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_active |=> (st == ST_IDLE));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .hit         (hit),
    .any_en      (any_en),
    .alm_flag    (alm_flag),
    .flag_clr    (flag_clr),
    .alarm_active(alarm_active),
    .fsel        (fsel),
    .batt_mode   (batt_mode),
    .batt_keep   (batt_keep),
    .irq_oe      (irq_oe),
    .st          (st_w)
);

// File: tb/rtc_alarm_irq_tb_top.sv
module rtc_alarm_irq_tb_top;
    localparam int PULSE = 8192;

    // {alarm sec..dow (48), current sec..dow (48), expected match}
    localparam logic [96:0] VEC [0:7] = '{
        {48'hB0_00_00_00_00_00, 48'h30_00_00_00_00_00, 1'b1},
        {48'hB0_00_00_00_00_00, 48'h31_00_00_00_00_00, 1'b0},
        {48'hB0_85_00_00_00_00, 48'h30_05_00_00_00_00, 1'b1},
        {48'hB0_85_00_00_00_00, 48'h30_06_00_00_00_00, 1'b0},
        {48'h30_05_00_00_00_00, 48'h30_05_00_00_00_00, 1'b0},
        {48'hB0_85_92_A4_86_83, 48'h30_05_12_24_06_03, 1'b1},
        {48'hB0_85_92_A4_86_83, 48'h30_05_12_24_06_04, 1'b0},
        {48'hB0_05_00_00_00_00, 48'h30_07_00_00_00_00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 0, pulse_mode = 0, auto_clr = 0, flag_rd = 0, flag_clr = 0;
    logic batt_mode = 0, batt_keep = 0;
    logic [3:0] fsel = '0;
    logic [7:0] c_sec, c_min, c_hour, c_date, c_mon, c_dow;
    logic [7:0] a_sec, a_min, a_hour, a_date, a_mon, a_dow;
    logic alm_flag, irq_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_alarm_irq dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(c_sec), .cur_min(c_min), .cur_hour(c_hour),
        .cur_date(c_date), .cur_mon(c_mon), .cur_dow(c_dow),
        .alm_sec(a_sec), .alm_min(a_min), .alm_hour(a_hour),
        .alm_date(a_date), .alm_mon(a_mon), .alm_dow(a_dow),
        .pulse_mode(pulse_mode), .auto_clr(auto_clr), .flag_rd(flag_rd),
        .flag_clr(flag_clr), .fsel(fsel), .batt_mode(batt_mode),
        .batt_keep(batt_keep), .alm_flag(alm_flag), .irq_oe(irq_oe)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic load(input int i);
        {a_sec, a_min, a_hour, a_date, a_mon, a_dow} = VEC[i][96:49];
        {c_sec, c_min, c_hour, c_date, c_mon, c_dow} = VEC[i][48:1];
    endtask

    task automatic tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic sw_clear();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int ones;
        logic prev;
        load(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 flag after reset", alm_flag, 1'b0);
        check("R11 pin after reset", irq_oe, 1'b0);

        // R1 / R2 / R3: table walk in latched mode
        for (int i = 0; i < 8; i++) begin
            load(i);
            tick();
            check($sformatf("R1 R2 vec%0d flag", i), alm_flag, VEC[i][0]);
            check($sformatf("R3 R9 vec%0d pin", i), irq_oe, VEC[i][0]);
            sw_clear();
            check($sformatf("R6 vec%0d cleared", i), alm_flag, 1'b0);
        end

        // R3: latched pin holds
        load(0);
        tick();
        repeat (20) @(negedge clk);
        check("R3 latched pin holds", irq_oe, 1'b1);
        sw_clear();
        check("R6 latched pin released", irq_oe, 1'b0);

        // R6: match wins over clear
        @(negedge clk) begin flag_clr = 1'b1; sec_tick = 1'b1; end
        @(negedge clk) begin flag_clr = 1'b0; sec_tick = 1'b0; end
        check("R6 match beats clear", alm_flag, 1'b1);

        // R7: read without auto clear has no effect
        @(negedge clk) flag_rd = 1'b1;
        @(negedge clk) flag_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 read ignored without auto", alm_flag, 1'b1);
        // R7: auto clear timing
        @(negedge clk) begin auto_clr = 1'b1; flag_rd = 1'b1; end
        @(negedge clk) flag_rd = 1'b0;
        check("R7 flag one edge after read", alm_flag, 1'b1);
        @(negedge clk);
        check("R7 flag cleared second edge", alm_flag, 1'b0);
        check("R7 pin released", irq_oe, 1'b0);
        auto_clr = 1'b0;

        // R4 / R5: pulsed mode
        pulse_mode = 1'b1;
        tick();
        check("R4 pulse start", irq_oe, 1'b1);
        repeat (PULSE - 1) @(negedge clk);
        check("R4 last pulse cycle", irq_oe, 1'b1);
        @(negedge clk);
        check("R4 pulse ended", irq_oe, 1'b0);
        check("R5 flag stays after pulse", alm_flag, 1'b1);
        tick();
        repeat (4000) @(negedge clk);
        tick();
        repeat (PULSE - 1) @(negedge clk);
        check("R4 retrigger extends", irq_oe, 1'b1);
        @(negedge clk);
        check("R4 retrigger end", irq_oe, 1'b0);
        pulse_mode = 1'b0;
        sw_clear();

        // R8: clock output
        @(negedge clk) fsel = 4'd1;
        @(negedge clk) prev = irq_oe;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R8 code1 toggles each cycle", irq_oe, !prev);
            prev = irq_oe;
        end
        fsel = 4'd3;
        ones = 0;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            if (irq_oe) ones++;
        end
        check("R8 code3 duty half", ones == 16, 1'b1);
        load(0);
        tick();
        check("R8 match ignored with clock out", alm_flag, 1'b0);
        fsel = 4'd0;
        @(negedge clk);
        check("R8 alarm pin idle after clock out", irq_oe, 1'b0);

        // R10 / R12: backup supply
        tick();
        check("R3 latched before backup", irq_oe, 1'b1);
        @(negedge clk) batt_mode = 1'b1;
        @(negedge clk);
        check("R10 pin quiet on backup", irq_oe, 1'b0);
        check("R12 flag kept on backup", alm_flag, 1'b1);
        sw_clear();
        tick();
        check("R10 match ignored on backup", alm_flag, 1'b0);
        @(negedge clk) batt_keep = 1'b1;
        @(negedge clk);
        check("R12 pin stays released", irq_oe, 1'b0);
        tick();
        check("R10 keep-alive flag", alm_flag, 1'b1);
        check("R10 keep-alive pin", irq_oe, 1'b1);

        finish_run();
    end
endmodule